// File: doc/BRIEF.md
# On-Demand Register Rename Allocator

This block translates per-warp logical register names into physical register numbers. The few lowest-numbered logical registers of every warp sit in fixed physical slots. Every higher-numbered logical register is bound to a physical register only when it is first written, and the binding is drawn from a shared pool. Because the physical file only needs to hold values that are live at a given moment, it can be much smaller than the full logical name space of all warps.

A read can carry a final-use mark. When that mark arrives, the binding is released and its physical register goes back to the pool. While a divergence mask is raised, such releases are only noted. They take effect together when the reconvergence pulse arrives, so a value that another divergent path still needs stays in place.

The pool is a bitmap split into equal subarrays. A per-subarray all-free flag tells power control which groups of physical registers can be gated off. Translations appear in the same cycle as the request. Bindings and releases take effect at the next clock edge.

Top module: `rename_alloc`

## Requirements
- R1: A logical register below STATIC_REGS maps to physical number warp*STATIC_REGS + lreg on both ports, and never draws from the pool.
- R2: A write to an unbound renamed register (lreg >= STATIC_REGS) binds the lowest-numbered free pool entry k. In that cycle wr_preg shows NUM_WARPS*STATIC_REGS + k, and free_count drops by one after the clock edge.
- R3: Later writes and reads of a bound register return the same physical number, and they allocate nothing.
- R4: A write to an unbound renamed register while the pool is empty raises wr_stall in that cycle. No binding is made and free_count does not change.
- R5: A read of an unbound renamed register returns rd_preg = 0 with rd_err = 1.
- R6: A read with rd_last = 1 and div_active = 0 removes the binding at the clock edge and returns its pool entry. A later read of that register then reports rd_err.
- R7: A read with rd_last = 1 and div_active = 1 keeps the binding readable and the entry allocated. A one-cycle reconv pulse later releases every binding deferred this way.
- R8: sub_free[s] is 1 exactly when pool entries s*SUB_SIZE to s*SUB_SIZE+SUB_SIZE-1 are all free.
- R9: After a synchronous active-low reset, no binding exists, free_count equals the pool size, every sub_free bit is 1 and pool_empty is 0.
- R10: rd_last on a static register, or on an unbound renamed register, leaves the pool unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write-side translation request |
| wr_warp | input | WARP_W | Warp of the write |
| wr_lreg | input | LREG_W | Logical register written |
| wr_preg | output | PREG_W | Physical register for the write (0 when stalled) |
| wr_stall | output | 1 | Write needs a binding but the pool is empty |
| rd_en | input | 1 | Read-side translation request |
| rd_warp | input | WARP_W | Warp of the read |
| rd_lreg | input | LREG_W | Logical register read |
| rd_last | input | 1 | Final use of this value |
| rd_preg | output | PREG_W | Physical register for the read (0 on error) |
| rd_err | output | 1 | Read of an unbound renamed register |
| div_active | input | 1 | Defer final-use releases |
| reconv | input | 1 | Release all deferred bindings |
| free_count | output | CNT_W | Number of free pool entries |
| pool_empty | output | 1 | No pool entry free |
| sub_free | output | NSUB | Per-subarray all-free flags |

## Verification
The bench builds the block with 4 warps of 16 logical registers, 4 static registers per warp and 32 physical registers. That leaves a 16-entry pool in four subarrays of four, facing 48 renamable names. These sizes let the bench drain the pool completely with sixteen writes and then hit the stall. It can also free one whole subarray so its flag rises alone, and it can show that a freed entry is reused as the lowest-numbered one. The same settings exercise the deferred release around a divergent region and the reset that clears all bindings.

// File: rtl/ra_pkg.sv
// Package ra_pkg
// Shared types for the rename allocator. Assumes nothing beyond 1800-2017.
package ra_pkg;
    // How a logical register is placed in the physical file
    typedef enum logic {
        RK_STATIC  = 1'b0,
        RK_RENAMED = 1'b1
    } rkind_t;
endpackage

// File: rtl/ra_name_split.sv
// Module ra_name_split
// Classifies a (warp, logical register) pair as static or renamed. For a static
// register it gives the fixed physical slot. For a renamed one it gives the
// mapping-table entry index. Assumes LREGS > STATIC_REGS.
module ra_name_split
    import ra_pkg::*;
#(
    parameter int NUM_WARPS   = 4,
    parameter int LREGS       = 16,
    parameter int STATIC_REGS = 4,
    parameter int NUM_PREGS   = 32,
    localparam int WARP_W     = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1,
    localparam int LREG_W     = $clog2(LREGS),
    localparam int PREG_W     = $clog2(NUM_PREGS),
    localparam int RN         = LREGS - STATIC_REGS,
    localparam int ENTRIES    = NUM_WARPS * RN,
    localparam int ENT_W      = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic [WARP_W-1:0] warp,
    input  logic [LREG_W-1:0] lreg,
    output rkind_t            kind,
    output logic [PREG_W-1:0] static_preg,
    output logic [ENT_W-1:0]  map_idx
);
    // Compute the class, the fixed slot and the table index of the name
    always_comb begin
        kind        = (int'(lreg) < STATIC_REGS) ? RK_STATIC : RK_RENAMED;
        static_preg = PREG_W'(int'(warp) * STATIC_REGS + int'(lreg));
        map_idx     = ENT_W'(int'(warp) * RN + int'(lreg) - STATIC_REGS);
    end
endmodule

// File: rtl/ra_free_pool.sv
// Module ra_free_pool
// Free bitmap of the renamable pool. A priority encoder offers the lowest free
// entry, a population count gives the number free, and per-subarray AND trees
// give the all-free flags. Assumes POOL is a multiple of SUB_SIZE and that
// take and release never name the same entry in one cycle.
module ra_free_pool #(
    parameter int POOL     = 16,
    parameter int SUB_SIZE = 4,
    localparam int POOL_W  = $clog2(POOL),
    localparam int CNT_W   = $clog2(POOL + 1),
    localparam int NSUB    = POOL / SUB_SIZE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic [POOL-1:0]   rel_mask,
    output logic [POOL_W-1:0] low_idx,
    output logic              avail,
    output logic [CNT_W-1:0]  free_count,
    output logic [NSUB-1:0]   sub_free
);
    logic [POOL-1:0] free_q;
    logic [POOL-1:0] free_d;

    // Priority encoder: the lowest-numbered free entry wins
    always_comb begin
        low_idx = '0;
        for (int i = POOL - 1; i >= 0; i--) begin
            if (free_q[i]) low_idx = POOL_W'(i);
        end
        avail = |free_q;
    end

    // Population count of the free bitmap
    always_comb begin
        free_count = '0;
        for (int i = 0; i < POOL; i++) begin
            free_count = free_count + CNT_W'(free_q[i]);
        end
    end

    // Next bitmap: clear the taken entry, set every released one
    always_comb begin
        free_d = free_q;
        if (take) free_d[low_idx] = 1'b0;
        free_d = free_d | rel_mask;
    end

    // Bitmap register, all entries free after reset
    always_ff @(posedge clk) begin
        if (!rst_n) free_q <= '1;
        else        free_q <= free_d;
    end

    // One all-free flag per subarray, for power gating
    for (genvar s = 0; s < NSUB; s++) begin : g_sub
        assign sub_free[s] = &free_q[s*SUB_SIZE +: SUB_SIZE];
    end
endmodule

// File: rtl/ra_map_table.sv
// Module ra_map_table
// Binding table for renamed registers: one valid bit, one deferred-release bit
// and one pool index per entry. Two lookup ports are combinational. Installs,
// immediate releases and releases on reconvergence apply at the clock edge, and
// every released entry is reported in rel_mask. Assumes an install only targets
// an unbound entry and a release only a bound one.
module ra_map_table #(
    parameter int ENTRIES = 48,
    parameter int POOL    = 16,
    localparam int ENT_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
    localparam int POOL_W = $clog2(POOL)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ENT_W-1:0]  a_idx,
    output logic              a_valid,
    output logic [POOL_W-1:0] a_pidx,
    input  logic [ENT_W-1:0]  b_idx,
    output logic              b_valid,
    output logic [POOL_W-1:0] b_pidx,
    input  logic              ins_en,
    input  logic [POOL_W-1:0] ins_pidx,
    input  logic              fr_en,
    input  logic              fr_defer,
    input  logic              reconv,
    output logic [POOL-1:0]   rel_mask
);
    logic [ENTRIES-1:0] valid_q, valid_d;
    logic [ENTRIES-1:0] pend_q, pend_d;
    logic [POOL_W-1:0]  pidx_q [ENTRIES];
    logic [POOL_W-1:0]  pidx_d [ENTRIES];

    // Combinational lookups for the write side (a) and the read side (b)
    always_comb begin
        a_valid = valid_q[a_idx];
        a_pidx  = pidx_q[a_idx];
        b_valid = valid_q[b_idx];
        b_pidx  = pidx_q[b_idx];
    end

    // Next table state and the mask of pool entries handed back
    always_comb begin
        valid_d  = valid_q;
        pend_d   = pend_q;
        pidx_d   = pidx_q;
        rel_mask = '0;
        if (reconv) begin
            for (int e = 0; e < ENTRIES; e++) begin
                if (valid_q[e] && pend_q[e]) begin
                    valid_d[e]          = 1'b0;
                    pend_d[e]           = 1'b0;
                    rel_mask[pidx_q[e]] = 1'b1;
                end
            end
        end
        if (fr_en && valid_q[b_idx]) begin
            if (fr_defer) begin
                if (valid_d[b_idx]) pend_d[b_idx] = 1'b1;
            end else begin
                valid_d[b_idx]          = 1'b0;
                pend_d[b_idx]           = 1'b0;
                rel_mask[pidx_q[b_idx]] = 1'b1;
            end
        end
        if (ins_en) begin
            valid_d[a_idx] = 1'b1;
            pend_d[a_idx]  = 1'b0;
            pidx_d[a_idx]  = ins_pidx;
        end
    end

    // Table registers, no bindings after reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            pend_q  <= '0;
            for (int e = 0; e < ENTRIES; e++) pidx_q[e] <= '0;
        end else begin
            valid_q <= valid_d;
            pend_q  <= pend_d;
            pidx_q  <= pidx_d;
        end
    end
endmodule

// File: rtl/rename_alloc.sv
// Module rename_alloc
// On-demand register rename allocator. Names below STATIC_REGS map to fixed
// slots at the bottom of the physical file. Higher names bind a pool register
// at first write and release it on a final-use read, deferred while
// div_active is high until a reconv pulse. Assumes
// NUM_PREGS > NUM_WARPS*STATIC_REGS and a pool size that is a multiple of
// SUB_SIZE.
module rename_alloc
    import ra_pkg::*;
#(
    parameter int NUM_WARPS      = 4,
    parameter int LREGS_PER_WARP = 16,
    parameter int STATIC_REGS    = 4,
    parameter int NUM_PREGS      = 32,
    parameter int SUB_SIZE       = 4,
    localparam int WARP_W  = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1,
    localparam int LREG_W  = $clog2(LREGS_PER_WARP),
    localparam int PREG_W  = $clog2(NUM_PREGS),
    localparam int BASE    = NUM_WARPS * STATIC_REGS,
    localparam int POOL    = NUM_PREGS - BASE,
    localparam int POOL_W  = $clog2(POOL),
    localparam int CNT_W   = $clog2(POOL + 1),
    localparam int NSUB    = POOL / SUB_SIZE,
    localparam int ENTRIES = NUM_WARPS * (LREGS_PER_WARP - STATIC_REGS),
    localparam int ENT_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WARP_W-1:0] wr_warp,
    input  logic [LREG_W-1:0] wr_lreg,
    output logic [PREG_W-1:0] wr_preg,
    output logic              wr_stall,
    input  logic              rd_en,
    input  logic [WARP_W-1:0] rd_warp,
    input  logic [LREG_W-1:0] rd_lreg,
    input  logic              rd_last,
    output logic [PREG_W-1:0] rd_preg,
    output logic              rd_err,
    input  logic              div_active,
    input  logic              reconv,
    output logic [CNT_W-1:0]  free_count,
    output logic              pool_empty,
    output logic [NSUB-1:0]   sub_free
);
    rkind_t             w_kind, r_kind;
    logic [PREG_W-1:0]  w_static, r_static;
    logic [ENT_W-1:0]   w_idx, r_idx;
    logic               w_hit, r_hit;
    logic [POOL_W-1:0]  w_pidx, r_pidx, low_idx;
    logic               avail;
    logic               need_alloc, alloc_take, fr_en;
    logic [POOL-1:0]    rel_mask;
    logic               rel_any;

    ra_name_split #(
        .NUM_WARPS(NUM_WARPS), .LREGS(LREGS_PER_WARP),
        .STATIC_REGS(STATIC_REGS), .NUM_PREGS(NUM_PREGS)
    ) u_wsplit (
        .warp(wr_warp), .lreg(wr_lreg),
        .kind(w_kind), .static_preg(w_static), .map_idx(w_idx)
    );

    ra_name_split #(
        .NUM_WARPS(NUM_WARPS), .LREGS(LREGS_PER_WARP),
        .STATIC_REGS(STATIC_REGS), .NUM_PREGS(NUM_PREGS)
    ) u_rsplit (
        .warp(rd_warp), .lreg(rd_lreg),
        .kind(r_kind), .static_preg(r_static), .map_idx(r_idx)
    );

    ra_map_table #(.ENTRIES(ENTRIES), .POOL(POOL)) u_map (
        .clk(clk), .rst_n(rst_n),
        .a_idx(w_idx), .a_valid(w_hit), .a_pidx(w_pidx),
        .b_idx(r_idx), .b_valid(r_hit), .b_pidx(r_pidx),
        .ins_en(alloc_take), .ins_pidx(low_idx),
        .fr_en(fr_en), .fr_defer(div_active), .reconv(reconv),
        .rel_mask(rel_mask)
    );

    ra_free_pool #(.POOL(POOL), .SUB_SIZE(SUB_SIZE)) u_pool (
        .clk(clk), .rst_n(rst_n),
        .take(alloc_take), .rel_mask(rel_mask),
        .low_idx(low_idx), .avail(avail),
        .free_count(free_count), .sub_free(sub_free)
    );

    // Write side: decide whether a binding is needed and whether it can be made
    always_comb begin
        need_alloc = wr_en && (w_kind == RK_RENAMED) && !w_hit;
        alloc_take = need_alloc && avail;
        wr_stall   = need_alloc && !avail;
        if (w_kind == RK_STATIC)  wr_preg = w_static;
        else if (w_hit)           wr_preg = PREG_W'(BASE + int'(w_pidx));
        else if (avail)           wr_preg = PREG_W'(BASE + int'(low_idx));
        else                      wr_preg = '0;
    end

    // Read side: translate, flag unbound reads, request a final-use release
    always_comb begin
        rd_err = rd_en && (r_kind == RK_RENAMED) && !r_hit;
        fr_en  = rd_en && rd_last && (r_kind == RK_RENAMED) && r_hit;
        if (r_kind == RK_STATIC) rd_preg = r_static;
        else if (r_hit)          rd_preg = PREG_W'(BASE + int'(r_pidx));
        else                     rd_preg = '0;
    end

    // Pool status seen by power control
    always_comb begin
        pool_empty = !avail;
        rel_any    = |rel_mask;
    end
endmodule

// File: rtl/ra_alloc_chk.sv
// Module ra_alloc_chk
// Checker bound to rename_alloc. It relates the stall, the error flag, the
// free count and the subarray flags over time. Assumes a synchronous
// active-low reset.
module ra_alloc_chk #(
    parameter int POOL  = 16,
    parameter int NSUB  = 4,
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_stall,
    input logic             pool_empty,
    input logic             rd_en,
    input logic             rd_err,
    input logic             alloc_take,
    input logic             rel_any,
    input logic [CNT_W-1:0] free_count,
    input logic [NSUB-1:0]  sub_free
);
    // A stall only happens on an empty pool
    assert_stall_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stall |-> pool_empty);

    // A stalled write never consumes a pool entry
    assert_stall_no_take_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stall |=> free_count >= $past(free_count));

    // A binding without a concurrent release costs exactly one entry
    assert_alloc_dec_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_take && !rel_any) |=> free_count == $past(free_count) - CNT_W'(1));

    // The error flag only accompanies a read request
    assert_err_needs_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_err |-> rd_en);

    // Full pool means every subarray is idle, empty pool means none is
    assert_sub_all_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (free_count == CNT_W'(POOL)) |-> (&sub_free));
    assert_sub_none_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (free_count == '0) |-> (sub_free == '0));

    // The first cycle after reset shows a full pool
    assert_reset_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (free_count == CNT_W'(POOL) && !pool_empty));

    // The count never exceeds the pool size
    assert_count_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        free_count <= CNT_W'(POOL));
endmodule

bind rename_alloc ra_alloc_chk #(.POOL(POOL), .NSUB(NSUB), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_stall(wr_stall), .pool_empty(pool_empty),
    .rd_en(rd_en), .rd_err(rd_err), .alloc_take(alloc_take), .rel_any(rel_any),
    .free_count(free_count), .sub_free(sub_free)
);

// File: tb/rename_alloc_test.sv
module rename_alloc_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0, rd_last = 1'b0;
    logic [1:0] wr_warp = '0, rd_warp = '0;
    logic [3:0] wr_lreg = '0, rd_lreg = '0;
    logic       div_active = 1'b0, reconv = 1'b0;
    logic [4:0] wr_preg, rd_preg, free_count;
    logic       wr_stall, rd_err, pool_empty;
    logic [3:0] sub_free;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rename_alloc uut (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_warp(wr_warp), .wr_lreg(wr_lreg),
        .wr_preg(wr_preg), .wr_stall(wr_stall),
        .rd_en(rd_en), .rd_warp(rd_warp), .rd_lreg(rd_lreg), .rd_last(rd_last),
        .rd_preg(rd_preg), .rd_err(rd_err),
        .div_active(div_active), .reconv(reconv),
        .free_count(free_count), .pool_empty(pool_empty), .sub_free(sub_free)
    );

    // op 0 = write, op 1 = read; flag is wr_stall for writes, rd_err for reads
    typedef struct packed {
        logic       op;
        logic [1:0] warp;
        logic [3:0] lreg;
        logic       last;
        logic [4:0] exp_preg;
        logic       exp_flag;
        logic [3:0] req;
    } vec_t;

    localparam int NVEC = 11;
    localparam vec_t VEC [NVEC] = '{
        '{1'b0, 2'd0, 4'd2,  1'b0, 5'd2,  1'b0, 4'd1},  // R1 static write
        '{1'b0, 2'd3, 4'd3,  1'b0, 5'd15, 1'b0, 4'd1},  // R1 static write, last slot
        '{1'b0, 2'd0, 4'd4,  1'b0, 5'd16, 1'b0, 4'd2},  // R2 first bind, entry 0
        '{1'b0, 2'd1, 4'd4,  1'b0, 5'd17, 1'b0, 4'd2},  // R2 second bind, entry 1
        '{1'b0, 2'd0, 4'd4,  1'b0, 5'd16, 1'b0, 4'd3},  // R3 rewrite keeps binding
        '{1'b1, 2'd0, 4'd4,  1'b0, 5'd16, 1'b0, 4'd3},  // R3 read of bound reg
        '{1'b1, 2'd2, 4'd9,  1'b0, 5'd0,  1'b1, 4'd5},  // R5 read of unbound reg
        '{1'b1, 2'd0, 4'd4,  1'b1, 5'd16, 1'b0, 4'd6},  // R6 final read frees
        '{1'b1, 2'd0, 4'd4,  1'b0, 5'd0,  1'b1, 4'd6},  // R6 binding gone
        '{1'b0, 2'd2, 4'd15, 1'b0, 5'd16, 1'b0, 4'd2},  // R2 lowest free reused
        '{1'b1, 2'd1, 4'd1,  1'b1, 5'd5,  1'b0, 4'd10}  // R10 final read of static
    };

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic drive_wr(input int w, input int l);
        @(negedge clk);
        wr_en = 1'b1; rd_en = 1'b0; reconv = 1'b0;
        wr_warp = 2'(w); wr_lreg = 4'(l);
        #1;
    endtask

    task automatic drive_rd(input int w, input int l, input logic last);
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b1; reconv = 1'b0; rd_last = last;
        rd_warp = 2'(w); rd_lreg = 4'(l);
        #1;
    endtask

    task automatic idle();
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0; rd_last = 1'b0; reconv = 1'b0;
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0; rd_last = 1'b0; reconv = 1'b0; div_active = 1'b0;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #1;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        do_reset();
        // R9 reset state
        chk("R9 free_count", int'(free_count), 16);
        chk("R9 sub_free", int'(sub_free), 15);
        chk("R9 pool_empty", int'(pool_empty), 0);

        // Vector table walk
        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i].op == 1'b0) begin
                drive_wr(int'(VEC[i].warp), int'(VEC[i].lreg));
                chk($sformatf("R%0d vec%0d wr_preg", VEC[i].req, i), int'(wr_preg), int'(VEC[i].exp_preg));
                chk($sformatf("R%0d vec%0d wr_stall", VEC[i].req, i), int'(wr_stall), int'(VEC[i].exp_flag));
            end else begin
                drive_rd(int'(VEC[i].warp), int'(VEC[i].lreg), VEC[i].last);
                chk($sformatf("R%0d vec%0d rd_preg", VEC[i].req, i), int'(rd_preg), int'(VEC[i].exp_preg));
                chk($sformatf("R%0d vec%0d rd_err", VEC[i].req, i), int'(rd_err), int'(VEC[i].exp_flag));
            end
        end
        idle();
        // Bound now: entry 0 (w2 r15), entry 1 (w1 r4)
        chk("R2 count after table", int'(free_count), 14);
        chk("R8 sub_free after table", int'(sub_free), 4'b1110);

        // R10: final read of an unbound renamed register
        drive_rd(3, 10, 1'b1);
        chk("R10 unbound err", int'(rd_err), 1);
        idle();
        chk("R10 count unchanged", int'(free_count), 14);

        // R7: deferred release inside a divergent region
        drive_wr(3, 5);
        chk("R7 bind", int'(wr_preg), 18);
        div_active = 1'b1;
        drive_rd(3, 5, 1'b1);
        chk("R7 final read preg", int'(rd_preg), 18);
        idle();
        chk("R7 held count", int'(free_count), 13);
        drive_rd(3, 5, 1'b0);
        chk("R7 still readable", int'(rd_preg), 18);
        chk("R7 still no err", int'(rd_err), 0);
        @(negedge clk);
        rd_en = 1'b0; reconv = 1'b1;
        idle();
        div_active = 1'b0;
        chk("R7 released count", int'(free_count), 14);
        drive_rd(3, 5, 1'b0);
        chk("R7 binding gone", int'(rd_err), 1);

        // R9: reset clears bindings
        do_reset();
        chk("R9 count after reset", int'(free_count), 16);
        drive_rd(2, 15, 1'b0);
        chk("R9 binding cleared", int'(rd_err), 1);

        // R4: drain the pool, then stall
        for (int i = 0; i < 16; i++) begin
            drive_wr(i / 4, 4 + (i % 4));
            chk("R2 drain preg", int'(wr_preg), 16 + i);
        end
        idle();
        chk("R4 empty count", int'(free_count), 0);
        chk("R4 pool_empty", int'(pool_empty), 1);
        chk("R8 none free", int'(sub_free), 0);
        drive_wr(0, 8);
        chk("R4 stall", int'(wr_stall), 1);
        idle();
        chk("R4 count kept", int'(free_count), 0);
        drive_rd(0, 8, 1'b0);
        chk("R4 no binding made", int'(rd_err), 1);

        // R6 release then rebind the freed entry
        drive_rd(0, 4, 1'b1);
        idle();
        chk("R6 one free", int'(free_count), 1);
        drive_wr(0, 8);
        chk("R6 rebind preg", int'(wr_preg), 16);
        chk("R6 rebind no stall", int'(wr_stall), 0);

        // R8: free subarray 3 (pool entries 12..15, warp 3 regs 4..7)
        for (int k = 0; k < 4; k++) drive_rd(3, 4 + k, 1'b1);
        idle();
        chk("R8 one subarray free", int'(sub_free), 4'b1000);
        chk("R8 count", int'(free_count), 4);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule